// File: doc/BRIEF.md
# Processor Run-State and Power-Mode Controller

This controller keeps track of the global operating state of a small 32-bit processor core. It watches three active-low pins: a power-on reset, a manual reset and a hardware-standby request. It also watches single-cycle strobes from the core: a sleep instruction together with its standby-select bit, a pending interrupt, a raised exception, the end of exception handling, and a bus request level. From these inputs it chooses one of eight states. It drives a registered one-hot state vector, a core clock enable, a bus grant and the privilege bit.

The three pins pass through two-flop synchronizers. Each synchronizer clears at once when its pin falls and releases only after two clock edges, so assertion of a pin acts at the next edge and release acts two edges later. The standby pin also gates the clock enable and the bus grant without waiting for a clock. Hardware standby has the highest priority, then power-on reset, then manual reset. Once in hardware standby, the block leaves it only through a power-on reset.

Top module: `pwr_state_ctrl`

## Requirements
- R1: `stateOneHot` has exactly one bit set. The bit positions are: 0 power-on reset, 1 manual reset, 2 exception handling, 3 program run, 4 bus released, 5 sleep, 6 standby, 7 hardware standby.
- R2: When `porRstN` is low and the block is not in hardware standby, the state at the next clock edge is power-on reset. This holds from any state.
- R3: When `hwStbyN` is low, the state at the next edge is hardware standby, whatever the other inputs are. While the pin is low, `coreClkEn` and `busGrant` read 0 at once, without waiting for a clock edge.
- R4: Hardware standby is left only for power-on reset. This needs the synchronized `hwStbyN` high and the synchronized `porRstN` low. With both pins high, the block stays in hardware standby.
- R5: A low `manRstN` enters manual reset from every state except hardware standby, where it is ignored. A low power-on reset wins over a low manual reset.
- R6: When the active reset pin has been high for two edges, the next edge moves the block from the reset state to exception handling.
- R7: In run state, `sleepStrobe` enters sleep when `stbySel` is 0 and standby when `stbySel` is 1.
- R8: `irqPend` in sleep or standby leads to exception handling. `irqPend` or `excRaise` in run state leads to exception handling, and this takes priority over a sleep strobe or a bus request in the same cycle.
- R9: `busReq` held high in run state enters bus released. The block returns to run on the first edge at which `busReq` is low.
- R10: `excDone` in exception handling enters run state. `privMode` is 1 in both reset states and in exception handling, and it is cleared on the step from exception handling to run.
- R11: `coreClkEn` is 0 in sleep, standby and hardware standby, and 1 in every other state.
- R12: `busGrant` is 1 only in the bus-released state.
- R13: A strobe that has no meaning in the current state is ignored. Examples are `excDone` outside exception handling and `irqPend` while the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset pin, active low, asynchronous |
| manRstN | input | 1 | Manual reset pin, active low, asynchronous |
| hwStbyN | input | 1 | Hardware standby pin, active low, asynchronous |
| sleepStrobe | input | 1 | Sleep instruction executed |
| stbySel | input | 1 | Standby-select bit sampled with the sleep strobe |
| irqPend | input | 1 | Interrupt pending |
| excRaise | input | 1 | Exception raised by the core |
| excDone | input | 1 | End of exception handling |
| busReq | input | 1 | External bus request level |
| stateOneHot | output | 8 | Registered one-hot state |
| coreClkEn | output | 1 | Core clock enable |
| busGrant | output | 1 | Bus grant |
| privMode | output | 1 | Privilege bit (1 privileged, 0 user) |

## Verification
The collisions that matter are an exception or interrupt arriving in the same run-state cycle as a bus request and a sleep strobe, and two pins falling together: power-on reset with manual reset, and standby with power-on reset. The bench drives these combinations on one clock edge. A behavioural model that follows the priority order in the requirements predicts which state wins, and the bench compares every output with the model on every cycle. The release of each pin is staggered so that the two-edge synchronizer delay is also checked against the model.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  localparam int NUM_ST = 8;
  localparam int ST_POR = 0;
  localparam int ST_MAN = 1;
  localparam int ST_EXC = 2;
  localparam int ST_RUN = 3;
  localparam int ST_BUS = 4;
  localparam int ST_SLP = 5;
  localparam int ST_STB = 6;
  localparam int ST_HWS = 7;

  typedef struct packed {
    logic [NUM_ST-1:0] nextState;
    logic              setPriv;
    logic              clrPriv;
  } ctrl_strobe_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pinN,
  output logic syncN
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge pinN) begin
    if (!pinN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign syncN = chain[STAGES-1];
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_state_pkg::*;
(
  input  logic         clk,
  input  logic         porSyncN,
  input  logic         manSyncN,
  input  logic         hwSyncN,
  input  logic         sleepStrobe,
  input  logic         stbySel,
  input  logic         irqPend,
  input  logic         excRaise,
  input  logic         excDone,
  input  logic         busReq,
  output ctrl_strobe_t strobe
);
  logic [NUM_ST-1:0] stateQ;
  logic [NUM_ST-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (!hwSyncN) begin
      nxt[ST_HWS] = 1'b1;
    end else if (stateQ[ST_HWS]) begin
      if (!porSyncN) nxt[ST_POR] = 1'b1;
      else           nxt[ST_HWS] = 1'b1;
    end else if (!porSyncN) begin
      nxt[ST_POR] = 1'b1;
    end else if (!manSyncN) begin
      nxt[ST_MAN] = 1'b1;
    end else if (stateQ[ST_POR] || stateQ[ST_MAN]) begin
      nxt[ST_EXC] = 1'b1;
    end else if (stateQ[ST_EXC]) begin
      if (excDone) nxt[ST_RUN] = 1'b1;
      else         nxt[ST_EXC] = 1'b1;
    end else if (stateQ[ST_RUN]) begin
      if (irqPend || excRaise) nxt[ST_EXC] = 1'b1;
      else if (sleepStrobe) begin
        if (stbySel) nxt[ST_STB] = 1'b1;
        else         nxt[ST_SLP] = 1'b1;
      end
      else if (busReq) nxt[ST_BUS] = 1'b1;
      else             nxt[ST_RUN] = 1'b1;
    end else if (stateQ[ST_BUS]) begin
      if (busReq) nxt[ST_BUS] = 1'b1;
      else        nxt[ST_RUN] = 1'b1;
    end else if (stateQ[ST_SLP]) begin
      if (irqPend) nxt[ST_EXC] = 1'b1;
      else         nxt[ST_SLP] = 1'b1;
    end else if (stateQ[ST_STB]) begin
      if (irqPend) nxt[ST_EXC] = 1'b1;
      else         nxt[ST_STB] = 1'b1;
    end else begin
      nxt[ST_POR] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    stateQ <= nxt;
  end

  always_comb begin
    strobe.nextState = nxt;
    strobe.setPriv   = nxt[ST_POR] | nxt[ST_MAN] | nxt[ST_EXC];
    strobe.clrPriv   = stateQ[ST_EXC] & nxt[ST_RUN];
  end
endmodule

// File: rtl/pwr_state_outreg.sv
module pwr_state_outreg
  import pwr_state_pkg::*;
(
  input  logic              clk,
  input  logic              hwStbyN,
  input  ctrl_strobe_t      strobe,
  output logic [NUM_ST-1:0] stateOneHot,
  output logic              coreClkEn,
  output logic              busGrant,
  output logic              privMode
);
  logic [NUM_ST-1:0] stateR;
  logic clkEnR;
  logic grantR;
  logic privR;

  always_ff @(posedge clk) begin
    stateR <= strobe.nextState;
    clkEnR <= ~(strobe.nextState[ST_SLP] | strobe.nextState[ST_STB] |
                strobe.nextState[ST_HWS]);
    grantR <= strobe.nextState[ST_BUS];
    if (strobe.setPriv)      privR <= 1'b1;
    else if (strobe.clrPriv) privR <= 1'b0;
  end

  assign stateOneHot = stateR;
  assign coreClkEn   = clkEnR & hwStbyN;
  assign busGrant    = grantR & hwStbyN;
  assign privMode    = privR;
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              manRstN,
  input  logic              hwStbyN,
  input  logic              sleepStrobe,
  input  logic              stbySel,
  input  logic              irqPend,
  input  logic              excRaise,
  input  logic              excDone,
  input  logic              busReq,
  output logic [NUM_ST-1:0] stateOneHot,
  output logic              coreClkEn,
  output logic              busGrant,
  output logic              privMode
);
  localparam int NUM_PINS = 3;

  logic [NUM_PINS-1:0] pinVec;
  logic [NUM_PINS-1:0] syncVec;
  ctrl_strobe_t strobe;

  assign pinVec = {hwStbyN, manRstN, porRstN};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sync
    pin_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk  (clk),
      .pinN (pinVec[i]),
      .syncN(syncVec[i])
    );
  end

  pwr_state_fsm uFsm (
    .clk        (clk),
    .porSyncN   (syncVec[0]),
    .manSyncN   (syncVec[1]),
    .hwSyncN    (syncVec[2]),
    .sleepStrobe(sleepStrobe),
    .stbySel    (stbySel),
    .irqPend    (irqPend),
    .excRaise   (excRaise),
    .excDone    (excDone),
    .busReq     (busReq),
    .strobe     (strobe)
  );

  pwr_state_outreg uOut (
    .clk        (clk),
    .hwStbyN    (hwStbyN),
    .strobe     (strobe),
    .stateOneHot(stateOneHot),
    .coreClkEn  (coreClkEn),
    .busGrant   (busGrant),
    .privMode   (privMode)
  );
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk
  import pwr_state_pkg::*;
(
  input logic              clk,
  input logic              hwStbyN,
  input logic [NUM_ST-1:0] stateOneHot,
  input logic              coreClkEn,
  input logic              busGrant,
  input logic              privMode
);
  logic [1:0] edgeCnt = 2'd0;
  logic armed;

  always_ff @(posedge clk) begin
    if (edgeCnt != 2'd3) edgeCnt <= edgeCnt + 2'd1;
  end
  assign armed = (edgeCnt == 2'd3);

  a_r1_one_hot: assert property (@(posedge clk) disable iff (!armed)
    $countones(stateOneHot) == 1);

  a_r3_hw_standby_entry: assert property (@(posedge clk) disable iff (!armed)
    !hwStbyN |=> stateOneHot[ST_HWS]);

  a_r4_hw_standby_exit: assert property (@(posedge clk) disable iff (!armed)
    ($past(stateOneHot[ST_HWS]) && !stateOneHot[ST_HWS]) |-> stateOneHot[ST_POR]);

  a_r10_priv_set: assert property (@(posedge clk) disable iff (!armed)
    (stateOneHot[ST_POR] || stateOneHot[ST_MAN] || stateOneHot[ST_EXC]) |-> privMode);

  a_r10_priv_clear: assert property (@(posedge clk) disable iff (!armed)
    ($past(stateOneHot[ST_EXC]) && stateOneHot[ST_RUN]) |-> !privMode);

  a_r11_clock_gate: assert property (@(posedge clk) disable iff (!armed)
    (stateOneHot[ST_SLP] || stateOneHot[ST_STB] || stateOneHot[ST_HWS]) |-> !coreClkEn);

  a_r12_grant_only_released: assert property (@(posedge clk) disable iff (!armed)
    busGrant |-> stateOneHot[ST_BUS]);
endmodule

bind pwr_state_ctrl pwr_state_chk uChk (
  .clk        (clk),
  .hwStbyN    (hwStbyN),
  .stateOneHot(stateOneHot),
  .coreClkEn  (coreClkEn),
  .busGrant   (busGrant),
  .privMode   (privMode)
);

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;
  localparam int S_POR = 0, S_MAN = 1, S_EXC = 2, S_RUN = 3;
  localparam int S_BUS = 4, S_SLP = 5, S_STB = 6, S_HWS = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic porRstN = 1'b0, manRstN = 1'b1, hwStbyN = 1'b1;
  logic sleepStrobe = 1'b0, stbySel = 1'b0, irqPend = 1'b0;
  logic excRaise = 1'b0, excDone = 1'b0, busReq = 1'b0;
  logic [7:0] stateOneHot;
  logic coreClkEn, busGrant, privMode;

  int total = 0;
  int bad = 0;
  string curReq = "R2";
  bit checkOn = 1'b0;

  int mState = S_POR;
  bit mPriv = 1'b1, mClk = 1'b1, mGrant = 1'b0;
  bit pH1 = 1'b0, pH2 = 1'b0, mH1 = 1'b1, mH2 = 1'b1, hH1 = 1'b1, hH2 = 1'b1;

  pwr_state_ctrl uut (
    .clk(clk), .porRstN(porRstN), .manRstN(manRstN), .hwStbyN(hwStbyN),
    .sleepStrobe(sleepStrobe), .stbySel(stbySel), .irqPend(irqPend),
    .excRaise(excRaise), .excDone(excDone), .busReq(busReq),
    .stateOneHot(stateOneHot), .coreClkEn(coreClkEn), .busGrant(busGrant),
    .privMode(privMode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic int modelNext(int s, bit eP, bit eM, bit eH);
    if (!eH) return S_HWS;
    if (s == S_HWS) return eP ? S_HWS : S_POR;
    if (!eP) return S_POR;
    if (!eM) return S_MAN;
    case (s)
      S_POR, S_MAN: return S_EXC;
      S_EXC: return excDone ? S_RUN : S_EXC;
      S_RUN: begin
        if (irqPend || excRaise) return S_EXC;
        if (sleepStrobe) return stbySel ? S_STB : S_SLP;
        if (busReq) return S_BUS;
        return S_RUN;
      end
      S_BUS: return busReq ? S_BUS : S_RUN;
      default: return irqPend ? S_EXC : s;
    endcase
  endfunction

  always @(posedge clk) begin
    bit eP, eM, eH;
    int nS;
    eP = porRstN && pH1 && pH2;
    eM = manRstN && mH1 && mH2;
    eH = hwStbyN && hH1 && hH2;
    nS = modelNext(mState, eP, eM, eH);
    if (nS == S_POR || nS == S_MAN || nS == S_EXC) mPriv = 1'b1;
    else if (mState == S_EXC && nS == S_RUN) mPriv = 1'b0;
    mState = nS;
    mClk = !(nS == S_SLP || nS == S_STB || nS == S_HWS);
    mGrant = (nS == S_BUS);
    pH2 = pH1; pH1 = porRstN;
    mH2 = mH1; mH1 = manRstN;
    hH2 = hH1; hH1 = hwStbyN;
    #2;
    if (checkOn) begin
      chk("R1", $countones(stateOneHot), 1);
      chk(curReq, int'(stateOneHot), 1 << mState);
      chk("R11", int'(coreClkEn), int'(mClk & hwStbyN));
      chk("R12", int'(busGrant), int'(mGrant & hwStbyN));
      chk("R6/R10", int'(privMode), int'(mPriv));
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    waitN(3);
    checkOn = 1'b1;
    curReq = "R2";
    waitN(2);
    curReq = "R6";       porRstN = 1'b1;  waitN(4);
    curReq = "R10";      excDone = 1'b1;  waitN(1); excDone = 1'b0; waitN(2);
    curReq = "R9";       busReq = 1'b1;   waitN(3);
    curReq = "R13";      excDone = 1'b1; irqPend = 1'b0; waitN(1); excDone = 1'b0; waitN(1);
    curReq = "R9";       busReq = 1'b0;   waitN(2);
    curReq = "R7";       sleepStrobe = 1'b1; stbySel = 1'b0; waitN(1); sleepStrobe = 1'b0; waitN(2);
    curReq = "R13";      excDone = 1'b1;  waitN(1); excDone = 1'b0; waitN(1);
    curReq = "R8";       irqPend = 1'b1;  waitN(1); irqPend = 1'b0; waitN(1);
    excDone = 1'b1; waitN(1); excDone = 1'b0; waitN(1);
    curReq = "R7";       sleepStrobe = 1'b1; stbySel = 1'b1; waitN(1); sleepStrobe = 1'b0; stbySel = 1'b0; waitN(2);
    curReq = "R8";       irqPend = 1'b1;  waitN(1); irqPend = 1'b0; waitN(1);
    excDone = 1'b1; waitN(1); excDone = 1'b0; waitN(1);
    curReq = "R8";       excRaise = 1'b1; busReq = 1'b1; sleepStrobe = 1'b1; waitN(1);
    excRaise = 1'b0; sleepStrobe = 1'b0; waitN(2);
    curReq = "R9";       excDone = 1'b1;  waitN(1); excDone = 1'b0; waitN(2);
    curReq = "R13";      irqPend = 1'b1;  waitN(1); irqPend = 1'b0; waitN(1);
    busReq = 1'b0; waitN(2);
    curReq = "R5";       manRstN = 1'b0;  waitN(2);
    porRstN = 1'b0; waitN(2);
    porRstN = 1'b1; waitN(4);
    manRstN = 1'b1; waitN(4);
    excDone = 1'b1; waitN(1); excDone = 1'b0; waitN(1);
    curReq = "R3";       busReq = 1'b1; waitN(2);
    hwStbyN = 1'b0; #1;
    chk("R3", int'(busGrant), 0);
    chk("R3", int'(coreClkEn), 0);
    waitN(2);
    busReq = 1'b0;
    curReq = "R5";       manRstN = 1'b0; irqPend = 1'b1; waitN(1); irqPend = 1'b0; waitN(3);
    manRstN = 1'b1; waitN(3);
    curReq = "R4";       hwStbyN = 1'b1; waitN(5);
    porRstN = 1'b0; waitN(3);
    porRstN = 1'b1; waitN(4);
    curReq = "R3";       hwStbyN = 1'b0; porRstN = 1'b0; waitN(3);
    curReq = "R4";       hwStbyN = 1'b1; waitN(4);
    porRstN = 1'b1; waitN(4);
    curReq = "R10";      excDone = 1'b1; waitN(1); excDone = 1'b0; waitN(3);
    checkOn = 1'b0;
    finishRun();
  end
endmodule